// File: doc/BRIEF.md
# ALU With Condition Code Register

This block joins an arithmetic/logic unit to a small bank of general registers. Each instruction names two source registers, a destination register and an operation. The two source values travel over an internal operand bus to the arithmetic circuitry, and the result returns to the destination register on the clock edge where the execute strobe is high. The operations are add, subtract, multiply, divide, AND, OR, NOT and compare.

A compare writes no register. It loads a dedicated three-bit condition code register that reports, on three separate pins, whether the first operand was greater than, equal to or less than the second. No other operation touches that register, so its flags stay valid while later arithmetic runs. There is no direct load path. Register contents are built up from the reset value of zero through the operations themselves.

A separate read port, addressed by its own index, shows the contents of any register at any time. Its output is combinational from the register bank.

Top module: `alu_cc_unit`

## Requirements
- R1: Reset, active low and asynchronous, clears every register to zero and clears all three condition flags.
- R2: With op code 0 (add) or 1 (subtract), the destination receives A+B or A-B modulo 2^W at the clock edge where exec_i is high.
- R3: Op code 2 (multiply) writes the low W bits of the unsigned product A*B.
- R4: Op code 3 (divide) writes the unsigned quotient A/B. When B is zero, it writes all ones and leaves the flags unchanged.
- R5: Op codes 4 and 5 write A AND B and A OR B. Op code 6 writes NOT A, and the value of the second source register has no effect on it.
- R6: Op code 7 (compare) writes no register and sets exactly one flag: flag_gt_o if A>B, flag_eq_o if A=B, flag_lt_o if A<B, all compared as unsigned values.
- R7: Every op code other than 7 leaves the three flags unchanged.
- R8: When exec_i is low at a clock edge, no register and no flag changes.
- R9: An operation whose destination is also one of its sources uses the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; the operation completes at this edge |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 mul, 3 div, 4 and, 5 or, 6 not, 7 compare) |
| src_a_i | input | $clog2(N) | First source register index |
| src_b_i | input | $clog2(N) | Second source register index |
| dst_i | input | $clog2(N) | Destination register index |
| rd_idx_i | input | $clog2(N) | Index for the read port |
| rd_data_o | output | W | Contents of the register selected by rd_idx_i |
| flag_gt_o | output | 1 | Last compare found A greater than B |
| flag_eq_o | output | 1 | Last compare found A equal to B |
| flag_lt_o | output | 1 | Last compare found A less than B |

## Verification
The hardest thing to reach from the ports is a register holding an arbitrary value, because the bank starts at zero and has no load path. The stimulus keeps R0 at zero and makes R1 equal to one: it computes NOT R0 and then subtracts that result from R0. It then builds each constant bit by bit, doubling the destination and adding R1 wherever the bit is set. With R0 never written, a zero divisor is always on hand for the divide-by-zero case. Values with the top bit set are built on purpose, so that the compare is shown to be unsigned.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_NOT = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cc_flags_t;

endpackage

// File: rtl/alu_cc_regs.sv
module alu_cc_regs #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    input  logic [IW-1:0] raddr_p,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_p
);

    logic [N-1:0][W-1:0] bank;

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (we && (waddr == IW'(g))) begin
                bank[g] <= wdata;
            end
        end
    end

    // operand bus: both sources and the read port are taken straight from the bank
    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];
    assign rdata_p = bank[raddr_p];

endmodule

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e    op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         wr_req,
    output logic         cc_load,
    output cc_flags_t    cc_next
);

    logic [W-1:0] quotient;

    assign quotient = (opnd_b == '0) ? '1 : (opnd_a / opnd_b);

    always_comb begin
        result  = '0;
        wr_req  = 1'b1;
        cc_load = 1'b0;
        unique case (op)
            OP_ADD: result = opnd_a + opnd_b;
            OP_SUB: result = opnd_a - opnd_b;
            OP_MUL: result = opnd_a * opnd_b;
            OP_DIV: result = quotient;
            OP_AND: result = opnd_a & opnd_b;
            OP_OR:  result = opnd_a | opnd_b;
            OP_NOT: result = ~opnd_a;
            OP_CMP: begin
                wr_req  = 1'b0;
                cc_load = 1'b1;
            end
            default: begin
                wr_req = 1'b0;
            end
        endcase
    end

    always_comb begin
        cc_next.gt = (opnd_a > opnd_b);
        cc_next.eq = (opnd_a == opnd_b);
        cc_next.lt = (opnd_a < opnd_b);
    end

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t next,
    output cc_flags_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= next;
        end
    end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_i,
    input  logic [2:0]    op_i,
    input  logic [IW-1:0] src_a_i,
    input  logic [IW-1:0] src_b_i,
    input  logic [IW-1:0] dst_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [W-1:0]  rd_data_o,
    output logic          flag_gt_o,
    output logic          flag_eq_o,
    output logic          flag_lt_o
);

    alu_op_e      op;
    logic [W-1:0] bus_a;
    logic [W-1:0] bus_b;
    logic [W-1:0] alu_res;
    logic         alu_wr;
    logic         alu_ccld;
    cc_flags_t    cc_d;
    cc_flags_t    cc_q;

    assign op = alu_op_e'(op_i);

    alu_cc_regs #(.W(W), .N(N), .IW(IW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (exec_i & alu_wr),
        .waddr   (dst_i),
        .wdata   (alu_res),
        .raddr_a (src_a_i),
        .raddr_b (src_b_i),
        .raddr_p (rd_idx_i),
        .rdata_a (bus_a),
        .rdata_b (bus_b),
        .rdata_p (rd_data_o)
    );

    alu_cc_datapath #(.W(W)) u_dp (
        .op      (op),
        .opnd_a  (bus_a),
        .opnd_b  (bus_b),
        .result  (alu_res),
        .wr_req  (alu_wr),
        .cc_load (alu_ccld),
        .cc_next (cc_d)
    );

    alu_cc_flags u_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (exec_i & alu_ccld),
        .next  (cc_d),
        .q     (cc_q)
    );

    assign flag_gt_o = cc_q.gt;
    assign flag_eq_o = cc_q.eq;
    assign flag_lt_o = cc_q.lt;

endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
    parameter int W  = 16,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic [2:0]    op_i,
    input logic [IW-1:0] rd_idx_i,
    input logic [W-1:0]  rd_data_o,
    input logic          flag_gt_o,
    input logic          flag_eq_o,
    input logic          flag_lt_o
);

    logic [2:0] flags;
    assign flags = {flag_gt_o, flag_eq_o, flag_lt_o};

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (flags == 3'b000)); // R1

    AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags)); // R6

    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 3'd7) |=> ($countones(flags) == 1)); // R6

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 3'd7) |=> (!$stable(rd_idx_i) || $stable(rd_data_o))); // R6

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i != 3'd7) |=> $stable(flags)); // R7

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(flags) && (!$stable(rd_idx_i) || $stable(rd_data_o)))); // R8

endmodule

bind alu_cc_unit alu_cc_checker #(.W(W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .op_i      (op_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .flag_gt_o (flag_gt_o),
    .flag_eq_o (flag_eq_o),
    .flag_lt_o (flag_lt_o)
);

// File: tb/alu_cc_unit_bench.sv
`timescale 1ns/1ps
module alu_cc_unit_bench;

    localparam int W  = 16;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec = 1'b0;
    logic [2:0]    op = '0;
    logic [IW-1:0] sa = '0, sb = '0, dst = '0, ridx = '0;
    logic [W-1:0]  rdata;
    logic          gt, eq, lt;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [W-1:0] mdl [N];
    logic [2:0]   mflags;

    always #4 clk = ~clk;

    alu_cc_unit #(.W(W), .N(N)) u_alu_cc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_i    (exec),
        .op_i      (op),
        .src_a_i   (sa),
        .src_b_i   (sb),
        .dst_i     (dst),
        .rd_idx_i  (ridx),
        .rd_data_o (rdata),
        .flag_gt_o (gt),
        .flag_eq_o (eq),
        .flag_lt_o (lt)
    );

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_result(logic [2:0] o, logic [W-1:0] a, logic [W-1:0] b);
        case (o)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a * b;
            3'd3: return (b == '0) ? '1 : a / b;
            3'd4: return a & b;
            3'd5: return a | b;
            3'd6: return ~a;
            default: return '0;
        endcase
    endfunction

    task automatic check_flags(string tag);
        check(tag, "flags", W'({gt, eq, lt}), W'(mflags));
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) begin
            ridx = IW'(i);
            #1;
            check(tag, $sformatf("reg %0d", i), rdata, mdl[i]);
        end
    endtask

    task automatic run_op(string tag, logic [2:0] o, int a, int b, int d);
        logic [W-1:0] va;
        logic [W-1:0] vb;
        va = mdl[a];
        vb = mdl[b];
        @(negedge clk);
        op = o; sa = IW'(a); sb = IW'(b); dst = IW'(d); ridx = IW'(d); exec = 1'b1;
        @(posedge clk);
        if (o == 3'd7)
            mflags = {va > vb, va == vb, va < vb};
        else
            mdl[d] = ref_result(o, va, vb);
        @(negedge clk);
        exec = 1'b0;
        check(tag, $sformatf("op %0d dst %0d", o, d), rdata, mdl[d]);
        check_flags(tag);
    endtask

    task automatic make_const(int d, logic [W-1:0] value);
        run_op("R2", 3'd1, d, d, d);
        for (int i = W - 1; i >= 0; i--) begin
            run_op("R9", 3'd0, d, d, d);
            if (value[i]) run_op("R2", 3'd0, d, 1, d);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) mdl[i] = '0;
        mflags = 3'b000;
        check_all("R1");
        check_flags("R1");
    endtask

    task automatic t_setup();
        run_op("R5", 3'd6, 0, 0, 1);
        run_op("R2", 3'd1, 0, 1, 1);
    endtask

    task automatic t_arith();
        make_const(2, 16'h1234);
        make_const(3, 16'h00F0);
        run_op("R2", 3'd0, 2, 3, 4);
        run_op("R2", 3'd1, 3, 2, 5);
        make_const(6, 16'hFFFF);
        run_op("R2", 3'd0, 6, 1, 7);
    endtask

    task automatic t_mul();
        make_const(2, 16'h0300);
        make_const(3, 16'h0101);
        run_op("R3", 3'd2, 2, 3, 4);
        make_const(5, 16'hFFFF);
        run_op("R3", 3'd2, 5, 5, 6);
    endtask

    task automatic t_div();
        make_const(2, 16'd1000);
        make_const(3, 16'd7);
        run_op("R4", 3'd3, 2, 3, 4);
        run_op("R4", 3'd3, 3, 2, 5);
        run_op("R6", 3'd7, 2, 3, 6);
        run_op("R4", 3'd3, 2, 0, 7);
    endtask

    task automatic t_logic();
        make_const(2, 16'hA5C3);
        make_const(3, 16'h0FF0);
        run_op("R5", 3'd4, 2, 3, 4);
        run_op("R5", 3'd5, 2, 3, 5);
        run_op("R5", 3'd6, 2, 3, 6);
        run_op("R5", 3'd6, 2, 1, 7);
        check("R5", "not ignores source b", mdl[6], mdl[7]);
    endtask

    task automatic t_compare();
        make_const(2, 16'h8000);
        make_const(3, 16'h0001);
        run_op("R6", 3'd7, 2, 3, 4);
        check_all("R6");
        run_op("R6", 3'd7, 3, 2, 4);
        run_op("R6", 3'd7, 3, 3, 4);
        run_op("R7", 3'd0, 2, 3, 5);
        run_op("R7", 3'd2, 2, 3, 5);
        run_op("R7", 3'd5, 2, 3, 5);
        check_all("R6");
    endtask

    task automatic t_idle();
        @(negedge clk);
        op = 3'd0; sa = 3'd2; sb = 3'd3; dst = 3'd4; exec = 1'b0;
        @(posedge clk);
        @(negedge clk);
        op = 3'd7;
        @(posedge clk);
        @(negedge clk);
        check_all("R8");
        check_flags("R8");
    endtask

    task automatic t_same_reg();
        make_const(2, 16'h0123);
        run_op("R9", 3'd1, 2, 2, 2);
        make_const(3, 16'h0040);
        run_op("R9", 3'd2, 3, 3, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_arith();
        t_mul();
        t_div();
        t_logic();
        t_compare();
        t_idle();
        t_same_reg();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule